// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a cycle-accurate, synthesizable model of a single-clock synchronous SRAM word array (256 words of 32 bits by default). Every synchronous input is registered on the rising clock edge: address, write data, chip select, address strobe, byte-lane enables, write qualifier and burst advance. A read returns its word one clock after its address is registered. A write lands in the array under per-lane control. A two-bit burst counter walks the four words of an aligned group, either in linear wrap order or in XOR-interleaved order.

An active-low address strobe with chip select low starts a burst at an external address. The strobe with chip select high deselects the block. While the strobe is high the burst continues on the internal address, and the advance input chooses whether the counter steps or holds for a wait state. Output enable and snooze act asynchronously on the drive flag. Snooze also gates every other input after a short latency, and the array keeps its contents while snooze is high.

Top module: `sbsram_top`

## Requirements
- R1: While reset is asserted and after reset is released, with no read issued, `rdValid` is 0.
- R2: Suppose `addrStb_n`=0 and `chipEn_n`=0 on edge N and the cycle is a read. The word at `addr` is then on `rdData` with `rdValid`=1 after edge N+1, given `outEn_n`=0.
- R3: Suppose `addrStb_n`=0 and `chipEn_n`=1 on edge N. The block then deselects, no operation is performed, and `rdValid` is 0 after edge N+1.
- R4: With `addrStb_n`=1, `chipEn_n` is ignored and an active burst carries on at its internal address.
- R5: A cycle writes only when `wrEn_n`=0 and at least one bit of `byteEn_n` is 0. Otherwise it is a read and leaves the array unchanged.
- R6: Bit i of `byteEn_n`, when low, writes lane i, which is `wrData[8i+7:8i]`. Lanes whose enable is high keep their stored value.
- R7: With `modeIlv`=1, the low two address bits of burst step k (k=0..3) are start XOR k.
- R8: With `modeIlv`=0, the low two bits of burst step k are (start+k) mod 4. The upper address bits never change during a burst.
- R9: With `addrStb_n`=1 and `advance`=0, the operation repeats at the same address as a wait state.
- R10: The step after the fourth word of a burst returns to the first address of the burst.
- R11: While `snooze`=1, `rdValid` is 0 at once. Two edges after `snooze` rises, all other inputs are ignored and the array keeps its contents. Sampling resumes two edges after `snooze` falls.
- R12: `outEn_n`=1 forces `rdValid` to 0 without changing stored read data. A write cycle never drives `rdValid`, whatever `outEn_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | External word address |
| wrData | input | 32 | Write data, sampled with its address |
| byteEn_n | input | 4 | Active-low byte-lane enables |
| wrEn_n | input | 1 | Active-low write qualifier |
| chipEn_n | input | 1 | Active-low chip select, used only with the strobe |
| addrStb_n | input | 1 | Active-low address strobe, starts a burst or deselects |
| advance | input | 1 | Steps the burst counter when the strobe is high |
| modeIlv | input | 1 | 1 selects interleaved order, 0 selects linear order |
| outEn_n | input | 1 | Asynchronous active-low output enable |
| snooze | input | 1 | Asynchronous low-power request |
| rdData | output | 32 | Registered read data |
| rdValid | output | 1 | Read-data drive flag (0 means high-Z) |

## Verification
On every cycle the assertions check the control rules. Deselect and snooze gating must leave no operation pending. A cycle that fails write qualification must never write. A wait state must hold the address, and the upper address bits must stay fixed while a burst runs. The fifth step must wrap to the start, and a write must never raise the drive flag. Only the bench scenarios show the data itself: the linear and interleaved address orders seen through read-back words, per-lane merging, contents kept across snooze, and the asynchronous effect of output enable and snooze on the drive flag.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  parameter int LANES = 4;

  typedef struct packed {
    logic             rdStb;
    logic             wrStb;
    logic [LANES-1:0] laneWe;
  } memCmd_t;

  function automatic logic [1:0] burstLow(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic       ilv);
    logic [1:0] res;
    if (ilv) res = start ^ step;
    else     res = start + step;
    return res;
  endfunction
endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SNZ_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addrStb_n,
  input  logic              chipEn_n,
  input  logic              advance,
  input  logic              modeIlv,
  input  logic              wrEn_n,
  input  logic [LANES-1:0]  byteEn_n,
  input  logic              snooze,
  output logic [ADDR_W-1:0] opAddr,
  output memCmd_t           cmd
);
  localparam int CW = $clog2(SNZ_LAT + 1);

  logic              gated;
  logic [CW-1:0]     snzCnt;
  logic              active;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        burstCnt;
  logic [1:0]        nextCnt;
  memCmd_t           cycCmd;

  always_comb begin
    nextCnt       = burstCnt + 2'd1;
    cycCmd.wrStb  = !wrEn_n && !(&byteEn_n);
    cycCmd.rdStb  = !cycCmd.wrStb;
    cycCmd.laneWe = cycCmd.wrStb ? ~byteEn_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gated    <= 1'b0;
      snzCnt   <= '0;
      active   <= 1'b0;
      baseAddr <= '0;
      burstCnt <= '0;
      opAddr   <= '0;
      cmd      <= '0;
    end else begin
      if (snooze != gated) begin
        if (snzCnt == CW'(SNZ_LAT - 1)) begin
          gated  <= snooze;
          snzCnt <= '0;
        end else begin
          snzCnt <= snzCnt + 1'b1;
        end
      end else begin
        snzCnt <= '0;
      end

      if (gated) begin
        cmd <= '0;
      end else if (!addrStb_n) begin
        if (!chipEn_n) begin
          active   <= 1'b1;
          baseAddr <= addr;
          burstCnt <= '0;
          opAddr   <= addr;
          cmd      <= cycCmd;
        end else begin
          active <= 1'b0;
          cmd    <= '0;
        end
      end else if (active) begin
        if (advance) begin
          burstCnt <= nextCnt;
          opAddr   <= {baseAddr[ADDR_W-1:2], burstLow(baseAddr[1:0], nextCnt, modeIlv)};
        end
        cmd <= cycCmd;
      end else begin
        cmd <= '0;
      end
    end
  end

  assert_deselect_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gated && !addrStb_n && chipEn_n) |=> (!cmd.rdStb && !cmd.wrStb));

  assert_ce_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gated && addrStb_n && active) |=> (cmd.rdStb || cmd.wrStb));

  assert_write_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gated && (wrEn_n || (&byteEn_n))) |=> !cmd.wrStb);

  assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gated && addrStb_n && active) |=> (opAddr[ADDR_W-1:2] == $past(opAddr[ADDR_W-1:2])));

  assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gated && addrStb_n && active && !advance) |=> (opAddr == $past(opAddr)));

  assert_wrap_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!gated && addrStb_n && active && advance && burstCnt == 2'd3) |=> (opAddr == baseAddr));

  assert_gated_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gated |=> (!cmd.rdStb && !cmd.wrStb));
endmodule

// File: rtl/sbsram_dpath.sv
module sbsram_dpath
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  memCmd_t                 cmd,
  input  logic [ADDR_W-1:0]       opAddr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEn_n,
  input  logic                    snooze,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] wrDataQ;
  logic              rdDrive;

  always_ff @(posedge clk) wrDataQ <= wrData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdDrive <= 1'b0;
    else        rdDrive <= cmd.rdStb;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (cmd.wrStb && cmd.laneWe[g]) laneMem[opAddr] <= wrDataQ[g*LANE_W +: LANE_W];
      if (cmd.rdStb) laneQ <= laneMem[opAddr];
    end
    assign rdData[g*LANE_W +: LANE_W] = laneQ;
  end

  assign rdValid = rdDrive && !outEn_n && !snooze;

  assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.rdStb |=> rdDrive);

  assert_write_no_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.wrStb |=> !rdDrive);
endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANE_W  = 8,
  parameter int SNZ_LAT = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic [LANES-1:0]        byteEn_n,
  input  logic                    wrEn_n,
  input  logic                    chipEn_n,
  input  logic                    addrStb_n,
  input  logic                    advance,
  input  logic                    modeIlv,
  input  logic                    outEn_n,
  input  logic                    snooze,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);
  memCmd_t           cmd;
  logic [ADDR_W-1:0] opAddr;

  sbsram_ctrl #(.ADDR_W(ADDR_W), .SNZ_LAT(SNZ_LAT)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .addrStb_n(addrStb_n),
    .chipEn_n(chipEn_n), .advance(advance), .modeIlv(modeIlv),
    .wrEn_n(wrEn_n), .byteEn_n(byteEn_n), .snooze(snooze),
    .opAddr(opAddr), .cmd(cmd)
  );

  sbsram_dpath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .opAddr(opAddr), .wrData(wrData),
    .outEn_n(outEn_n), .snooze(snooze), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/sbsram_top_tb_top.sv
`timescale 1ns/1ps
module sbsram_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic [31:0] wrData;
  logic [3:0]  byteEn_n;
  logic        wrEn_n, chipEn_n, addrStb_n, advance, modeIlv, outEn_n, snooze;
  logic [31:0] rdData;
  logic        rdValid;

  int checks = 0;
  int fails  = 0;
  logic [31:0] refMem [256];

  always #2.5 clk = ~clk;

  sbsram_top dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrData(wrData), .byteEn_n(byteEn_n),
    .wrEn_n(wrEn_n), .chipEn_n(chipEn_n), .addrStb_n(addrStb_n), .advance(advance),
    .modeIlv(modeIlv), .outEn_n(outEn_n), .snooze(snooze), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic driveIdle();
    addrStb_n = 1'b0; chipEn_n = 1'b1; wrEn_n = 1'b1; byteEn_n = 4'hF; advance = 1'b0;
  endtask

  task automatic driveOp(input logic [7:0] a, input logic wn, input logic [3:0] ben, input logic [31:0] d);
    addrStb_n = 1'b0; chipEn_n = 1'b0; addr = a; wrEn_n = wn; byteEn_n = ben; wrData = d; advance = 1'b0;
  endtask

  task automatic refWrite(input logic [7:0] a, input logic [3:0] ben, input logic [31:0] d);
    for (int i = 0; i < 4; i++) if (!ben[i]) refMem[a][8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [3:0] ben, input logic [31:0] d);
    @(negedge clk); driveOp(a, 1'b0, ben, d); refWrite(a, ben, d);
    @(negedge clk); driveIdle();
  endtask

  task automatic readCheck(input logic [7:0] a, input string tag);
    @(negedge clk); driveOp(a, 1'b1, 4'hF, 32'h0);
    @(negedge clk); driveIdle();
    @(negedge clk);
    check({tag, " valid"}, {31'b0, rdValid}, 32'd1);
    check({tag, " data"}, rdData, refMem[a]);
  endtask

  function automatic logic [7:0] stepAddr(input logic [7:0] s, input int k, input logic ilv);
    logic [1:0] kk = k[1:0];
    return ilv ? {s[7:2], s[1:0] ^ kk} : {s[7:2], s[1:0] + kk};
  endfunction

  task automatic burstRead(input logic [7:0] s, input logic ilv, input int nOps,
                           input logic ceHigh, input string tag);
    modeIlv = ilv;
    for (int i = 0; i < nOps + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check($sformatf("%s step%0d valid", tag, i - 2), {31'b0, rdValid}, 32'd1);
        check($sformatf("%s step%0d data", tag, i - 2), rdData, refMem[stepAddr(s, i - 2, ilv)]);
      end
      if (i == 0) driveOp(s, 1'b1, 4'hF, 32'h0);
      else if (i < nOps) begin
        addrStb_n = 1'b1; advance = 1'b1; chipEn_n = ceHigh;
      end else driveIdle();
    end
  endtask

  task automatic testReset();
    check("R1 in reset", {31'b0, rdValid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 after reset", {31'b0, rdValid}, 32'd0);
  endtask

  task automatic testFillRead();
    for (int a = 0; a < 64; a++) doWrite(a[7:0], 4'h0, 32'h5A000000 ^ (a * 32'h01030507));
    readCheck(8'h03, "R2 single read 03");
    readCheck(8'h2C, "R2 single read 2C");
  endtask

  task automatic testLanes();
    doWrite(8'h08, 4'b1010, 32'hC1C2C3C4);
    readCheck(8'h08, "R6 lanes 0 and 2");
    doWrite(8'h09, 4'b0111, 32'hEE000000);
    readCheck(8'h09, "R6 lane 3 only");
  endtask

  task automatic testWriteQual();
    @(negedge clk); driveOp(8'h0A, 1'b1, 4'h0, 32'hFFFFFFFF);
    @(negedge clk); driveOp(8'h0A, 1'b0, 4'hF, 32'hFFFFFFFF);
    @(negedge clk); driveIdle();
    check("R5 qualifier high reads", {31'b0, rdValid}, 32'd1);
    readCheck(8'h0A, "R5 array unchanged");
  endtask

  task automatic testSuspend();
    logic [7:0] expA [4] = '{8'h30, 8'h30, 8'h31, 8'h31};
    logic       advP [4] = '{1'b0, 1'b0, 1'b1, 1'b0};
    modeIlv = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) check($sformatf("R9 wait step%0d", i - 2), rdData, refMem[expA[i - 2]]);
      if (i == 0) driveOp(8'h30, 1'b1, 4'hF, 32'h0);
      else if (i < 4) begin addrStb_n = 1'b1; advance = advP[i]; end
      else driveIdle();
    end
  endtask

  task automatic testDeselect();
    @(negedge clk); driveOp(8'h07, 1'b1, 4'hF, 32'h0);
    @(negedge clk); driveIdle();
    @(negedge clk);
    check("R3 read before deselect", {31'b0, rdValid}, 32'd1);
    @(negedge clk);
    check("R3 deselected", {31'b0, rdValid}, 32'd0);
  endtask

  task automatic testBurstWrite();
    logic [31:0] d;
    modeIlv = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) check($sformatf("R12 write step%0d no drive", i - 2), {31'b0, rdValid}, 32'd0);
      d = 32'h77000000 + i;
      if (i == 0) begin driveOp(8'h3A, 1'b0, 4'h0, d); refWrite(8'h3A, 4'h0, d); end
      else if (i < 4) begin
        addrStb_n = 1'b1; advance = 1'b1; wrEn_n = 1'b0; byteEn_n = 4'h0; wrData = d;
        refWrite(stepAddr(8'h3A, i, 1'b0), 4'h0, d);
      end else driveIdle();
    end
    for (int k = 0; k < 4; k++) readCheck(stepAddr(8'h3A, k, 1'b0), "R8 burst write readback");
  endtask

  task automatic testOutEn();
    @(negedge clk); driveOp(8'h11, 1'b1, 4'hF, 32'h0);
    @(negedge clk); driveIdle();
    @(negedge clk);
    outEn_n = 1'b1; #0.5;
    check("R12 outEn high", {31'b0, rdValid}, 32'd0);
    outEn_n = 1'b0; #0.5;
    check("R12 outEn low valid", {31'b0, rdValid}, 32'd1);
    check("R12 outEn low data", rdData, refMem[8'h11]);
  endtask

  task automatic testSnooze();
    @(negedge clk); driveOp(8'h05, 1'b1, 4'hF, 32'h0);
    @(negedge clk); driveIdle();
    @(negedge clk);
    snooze = 1'b1; #0.5;
    check("R11 snooze forces high-Z", {31'b0, rdValid}, 32'd0);
    for (int i = 0; i < 4; i++) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); driveOp(8'h06, 1'b0, 4'h0, 32'hDEADBEEF);
    end
    @(negedge clk); driveOp(8'h06, 1'b1, 4'hF, 32'h0);
    @(negedge clk); driveIdle();
    @(negedge clk);
    check("R11 no read while snoozing", {31'b0, rdValid}, 32'd0);
    snooze = 1'b0;
    for (int i = 0; i < 4; i++) @(negedge clk);
    readCheck(8'h06, "R11 contents retained");
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    rst_n = 1'b0; addr = '0; wrData = '0; modeIlv = 1'b0; outEn_n = 1'b0; snooze = 1'b0;
    driveIdle();
    #1;
    testReset();
    testFillRead();
    testLanes();
    testWriteQual();
    burstRead(8'h12, 1'b0, 4, 1'b0, "R8 linear");
    burstRead(8'h12, 1'b0, 5, 1'b0, "R10 wrap");
    burstRead(8'h25, 1'b1, 4, 1'b0, "R7 interleave");
    burstRead(8'h1E, 1'b1, 5, 1'b0, "R10 interleave wrap");
    burstRead(8'h14, 1'b0, 4, 1'b1, "R4 chip enable ignored");
    testSuspend();
    testDeselect();
    testBurstWrite();
    testOutEn();
    testSnooze();
    @(negedge clk);
    finishRun();
  end
endmodule